// File: doc/BRIEF.md
# CAN Controller Clock-Stop and Wakeup Sequencer

This block sits beside a CAN protocol controller and runs its power-down handshake. A host register bit asks for a clock stop. The block forwards the request to the controller core and waits for the core's acknowledge. Once the acknowledge is present, the block switches off the core clock enable. While the core sleeps, only the always-on clock runs. The raw receive line is synchronized on that clock and watched for a recessive-to-dominant transition.

When wakeup on bus activity is enabled, that transition sets a sticky wakeup flag. It also turns the core clock back on and withdraws the clock stop request without the host. The core then drops its acknowledge. If automatic wakeup is also enabled, the block reads the controller's configuration word, clears its initialization bit and writes it back, so the core resumes full operation. Without automatic wakeup, the initialization bit is left for software. The frame that triggered the wakeup never reaches the core, because its clock was off, so the remote sender must transmit it again.

The host can also end sleep on its own by withdrawing its request. After a hardware wakeup, the host request must be seen low once before it can start another stop.

Top module: `can_sleep_ctl`

## Requirements
- R1: After reset, coreStopReq is 0, coreClkEn is 1, wakeFlag is 0, and rmwRdEn and rmwWrEn are 0.
- R2: With the host request armed, raising hostStopReq asserts coreStopReq at the next rising edge. coreClkEn goes to 0 at the edge where coreStopAck is sampled high.
- R3: coreClkEn changes only at an edge where coreStopAck is sampled high, so the core never sees a partial clock pulse.
- R4: While asleep with wakeEn=1, a 1-to-0 transition of rxLine is registered through a two-flop synchronizer. At the third rising edge after rxLine changes, wakeFlag becomes 1, coreStopReq becomes 0 and coreClkEn becomes 1; before that edge the core clock stays off. With wakeEn=0, rxLine activity leaves the block asleep and wakeFlag at 0.
- R5: After a bus wakeup with autoWakeEn=1, once coreStopAck has dropped, rmwRdEn is high for one cycle. rmwWrEn follows in the next cycle, with rmwWrData equal to the word read, bit INIT_BIT forced to 0 and every other bit unchanged. This is one write per wakeup.
- R6: After a bus wakeup with autoWakeEn=0, no read or write strobe is issued, and the block returns to its active state once coreStopAck drops.
- R7: If the host withdraws hostStopReq while asleep, coreClkEn returns to 1 and coreStopReq to 0. wakeFlag stays 0 and no read-modify-write occurs.
- R8: wakeFlag stays 1 until a cycle with wakeFlagClr=1 and no new detection. A detection in the same cycle as the clear leaves the flag at 1.
- R9: After a bus wakeup, a hostStopReq still held at 1 does not start a new stop. coreStopReq stays 0 until hostStopReq has been seen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostStopReq | input | 1 | Host clock stop request level |
| wakeEn | input | 1 | Enable wakeup on receive-line activity |
| autoWakeEn | input | 1 | Enable automatic clearing of the init bit after wakeup |
| wakeFlagClr | input | 1 | Host write of one to the wakeup flag |
| rxLine | input | 1 | Raw CAN receive line, 1 = recessive |
| coreStopAck | input | 1 | Clock stop acknowledge from the controller core |
| coreStopReq | output | 1 | Clock stop request to the controller core |
| coreClkEn | output | 1 | Core clock gate enable |
| wakeFlag | output | 1 | Sticky wakeup status |
| rmwRdEn | output | 1 | Read strobe for the controller configuration word |
| rmwRdData | input | REG_W | Configuration word read data, valid with rmwRdEn |
| rmwWrEn | output | 1 | Write strobe for the configuration word |
| rmwWrData | output | REG_W | Configuration word write data |

## Verification
The bench builds the block with a 16-bit configuration word, the init bit at position 3 and two synchronizer stages. The non-zero bit position makes visible any write that clears the wrong bit or disturbs the bits beside it. A 16-bit random word gives many distinct neighbour patterns. The two-stage depth pins the bus-wakeup latency to exactly three edges, so detection that comes early or late is caught.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_STOPREQ,
    ST_SLEEP,
    ST_WAKE,
    ST_RMWRD,
    ST_RMWWR
  } slpState_t;

  typedef struct packed {
    logic setFlag;
    logic clkOff;
    logic clkOn;
    logic rmwCapture;
    logic rmwWrite;
  } slpStrobe_t;

endpackage

// File: rtl/can_sleep_dp.sv
module can_sleep_dp
  import can_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8,
  parameter int INIT_BIT    = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             wakeFlagClr,
  input  logic             coreStopAck,
  input  slpStrobe_t       strb,
  input  logic [REG_W-1:0] rmwRdData,
  output logic             rxFall,
  output logic             coreClkEn,
  output logic             wakeFlag,
  output logic             rmwRdEn,
  output logic             rmwWrEn,
  output logic [REG_W-1:0] rmwWrData
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [REG_W-1:0] INIT_MASK = REG_W'(1) << INIT_BIT;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   clkEnQ;
  logic                   flagQ;
  logic [REG_W-1:0]       wordQ;

  // receive line synchronizer, idles recessive
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= rxLine;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[LAST];
  end

  assign rxFall = prevQ & ~syncQ[LAST];

  // clock gate enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            clkEnQ <= 1'b1;
    else if (strb.clkOff) clkEnQ <= 1'b0;
    else if (strb.clkOn)  clkEnQ <= 1'b1;
  end

  // sticky wakeup flag, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (wakeFlagClr)  flagQ <= 1'b0;
  end

  // read-modify-write capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordQ <= '0;
    else if (strb.rmwCapture) wordQ <= rmwRdData;
  end

  assign coreClkEn = clkEnQ;
  assign wakeFlag  = flagQ;
  assign rmwRdEn   = strb.rmwCapture;
  assign rmwWrEn   = strb.rmwWrite;
  assign rmwWrData = wordQ & ~INIT_MASK;

  // R3: gate toggles only at an edge where acknowledge was high
  a_r3_gate_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn != $past(coreClkEn)) |-> $past(coreStopAck));

  // R5: init bit cleared, neighbours kept from the word read
  a_r5_init_cleared: assert property (@(posedge clk) disable iff (!rstN)
    rmwWrEn |-> !rmwWrData[INIT_BIT]);

  a_r5_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    rmwWrEn |-> ((rmwWrData | INIT_MASK) == ($past(rmwRdData) | INIT_MASK)));

  // R5: write always preceded by a read cycle
  a_r5_read_first: assert property (@(posedge clk) disable iff (!rstN)
    rmwWrEn |-> $past(rmwRdEn));

endmodule

// File: rtl/can_sleep_fsm.sv
module can_sleep_fsm
  import can_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostStopReq,
  input  logic       wakeEn,
  input  logic       autoWakeEn,
  input  logic       coreStopAck,
  input  logic       rxFall,
  input  logic       coreClkEn,
  output logic       coreStopReq,
  output slpStrobe_t strb
);

  slpState_t stateQ, stateD;
  logic      armedQ;
  logic      autoQ;
  logic      hwWake;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    hwWake = 1'b0;
    unique case (stateQ)
      ST_ACTIVE: begin
        if (hostStopReq && armedQ) stateD = ST_STOPREQ;
      end
      ST_STOPREQ: begin
        if (coreStopAck) begin
          stateD      = ST_SLEEP;
          strb.clkOff = 1'b1;
        end else if (!hostStopReq) begin
          stateD = ST_WAKE;
        end
      end
      ST_SLEEP: begin
        if (wakeEn && rxFall) begin
          stateD       = ST_WAKE;
          strb.clkOn   = 1'b1;
          strb.setFlag = 1'b1;
          hwWake       = 1'b1;
        end else if (!hostStopReq) begin
          stateD     = ST_WAKE;
          strb.clkOn = 1'b1;
        end
      end
      ST_WAKE: begin
        if (!coreStopAck) stateD = autoQ ? ST_RMWRD : ST_ACTIVE;
      end
      ST_RMWRD: begin
        strb.rmwCapture = 1'b1;
        stateD          = ST_RMWWR;
      end
      ST_RMWWR: begin
        strb.rmwWrite = 1'b1;
        stateD        = ST_ACTIVE;
      end
      default: stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACTIVE;
    else       stateQ <= stateD;
  end

  // host request must be seen low before a new stop after bus wakeup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            armedQ <= 1'b1;
    else if (!hostStopReq) armedQ <= 1'b1;
    else if (hwWake)      armedQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    autoQ <= 1'b0;
    else if (hwWake)              autoQ <= autoWakeEn;
    else if (stateQ == ST_ACTIVE) autoQ <= 1'b0;
  end

  assign coreStopReq = (stateQ == ST_STOPREQ) || (stateQ == ST_SLEEP);

  // R2: armed host request reaches the core one edge later
  a_r2_req_forward: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && hostStopReq && armedQ) |=> coreStopReq);

  // R4: core clock is off for the whole sleep
  a_r4_off_asleep: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP) |-> !coreClkEn);

  // R4: enabled bus activity ends sleep at the next edge
  a_r4_bus_wake: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && wakeEn && rxFall) |=> (!coreStopReq && coreClkEn));

  // R6: without auto-wakeup the wake state leads straight back to active
  a_r6_no_rmw: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAKE && !autoQ) |=> (stateQ == ST_WAKE || stateQ == ST_ACTIVE));

  // R9: a new stop request only starts when armed
  a_r9_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (!coreStopReq ##1 coreStopReq) |-> $past(armedQ));

endmodule

// File: rtl/can_sleep_ctl.sv
module can_sleep_ctl
  import can_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8,
  parameter int INIT_BIT    = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostStopReq,
  input  logic             wakeEn,
  input  logic             autoWakeEn,
  input  logic             wakeFlagClr,
  input  logic             rxLine,
  input  logic             coreStopAck,
  output logic             coreStopReq,
  output logic             coreClkEn,
  output logic             wakeFlag,
  output logic             rmwRdEn,
  input  logic [REG_W-1:0] rmwRdData,
  output logic             rmwWrEn,
  output logic [REG_W-1:0] rmwWrData
);

  slpStrobe_t strb;
  logic       rxFall;

  can_sleep_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .hostStopReq (hostStopReq),
    .wakeEn      (wakeEn),
    .autoWakeEn  (autoWakeEn),
    .coreStopAck (coreStopAck),
    .rxFall      (rxFall),
    .coreClkEn   (coreClkEn),
    .coreStopReq (coreStopReq),
    .strb        (strb)
  );

  can_sleep_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .REG_W       (REG_W),
    .INIT_BIT    (INIT_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .wakeFlagClr (wakeFlagClr),
    .coreStopAck (coreStopAck),
    .strb        (strb),
    .rmwRdData   (rmwRdData),
    .rxFall      (rxFall),
    .coreClkEn   (coreClkEn),
    .wakeFlag    (wakeFlag),
    .rmwRdEn     (rmwRdEn),
    .rmwWrEn     (rmwWrEn),
    .rmwWrData   (rmwWrData)
  );

endmodule

// File: tb/sim_can_sleep_ctl.sv
`timescale 1ns/1ps
module sim_can_sleep_ctl;

  localparam int REG_W    = 16;
  localparam int INIT_BIT = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hostStopReq = 1'b0;
  logic             wakeEn = 1'b0;
  logic             autoWakeEn = 1'b0;
  logic             wakeFlagClr = 1'b0;
  logic             rxLine = 1'b1;
  logic             coreStopAck;
  logic             coreStopReq;
  logic             coreClkEn;
  logic             wakeFlag;
  logic             rmwRdEn;
  logic [REG_W-1:0] rmwRdData;
  logic             rmwWrEn;
  logic [REG_W-1:0] rmwWrData;

  logic [REG_W-1:0] ctrlReg;
  logic [1:0]       ackDly;
  int               nChecks = 0;
  int               nFails = 0;
  int               wrCnt = 0;
  logic [REG_W-1:0] lastWr;
  logic             prevRdEn = 1'b0;
  logic             prevClkEn = 1'b1;
  logic             prevAck = 1'b0;
  int               cycles = 0;
  bit               finished = 1'b0;

  always #2 clk = ~clk;

  can_sleep_ctl #(.SYNC_STAGES(2), .REG_W(REG_W), .INIT_BIT(INIT_BIT)) u0 (
    .clk(clk), .rstN(rstN), .hostStopReq(hostStopReq), .wakeEn(wakeEn),
    .autoWakeEn(autoWakeEn), .wakeFlagClr(wakeFlagClr), .rxLine(rxLine),
    .coreStopAck(coreStopAck), .coreStopReq(coreStopReq), .coreClkEn(coreClkEn),
    .wakeFlag(wakeFlag), .rmwRdEn(rmwRdEn), .rmwRdData(rmwRdData),
    .rmwWrEn(rmwWrEn), .rmwWrData(rmwWrData)
  );

  // core model: acknowledge follows the request after two edges, drops only with clock
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreStopAck <= 1'b0;
      ackDly      <= '0;
    end else if (coreStopReq != coreStopAck && (coreStopReq || coreClkEn)) begin
      if (ackDly == 2'd1) begin
        coreStopAck <= coreStopReq;
        ackDly      <= '0;
      end else begin
        ackDly <= ackDly + 2'd1;
      end
    end else begin
      ackDly <= '0;
    end
  end

  // configuration word model
  always @(posedge clk) if (rstN && rmwWrEn) ctrlReg <= rmwWrData;
  assign rmwRdData = ctrlReg;

  function automatic logic [REG_W-1:0] expWord(input logic [REG_W-1:0] v);
    return v & ~(REG_W'(1) << INIT_BIT);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitors sampled at falling edges
  always @(negedge clk) begin
    if (rstN) begin
      if (coreClkEn != prevClkEn)
        chk(prevAck, "R3", "gate changed without acknowledge", prevAck, 1);
      if (rmwWrEn) begin
        wrCnt++;
        lastWr = rmwWrData;
        chk(prevRdEn, "R5", "read strobe before write", prevRdEn, 1);
      end
    end
    prevClkEn = coreClkEn;
    prevAck   = coreStopAck;
    prevRdEn  = rmwRdEn;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic goSleep();
    @(negedge clk);
    hostStopReq = 1'b1;
    @(negedge clk);
    chk(coreStopReq == 1'b1, "R2", "request forwarded", coreStopReq, 1);
    for (int i = 0; i < 10 && coreClkEn; i++) @(negedge clk);
    chk(coreClkEn == 1'b0, "R2", "clock gated after ack", coreClkEn, 0);
  endtask

  task automatic runCase(input bit we, input bit ae, input logic [REG_W-1:0] val,
                         input bit holdClr);
    @(negedge clk);
    hostStopReq = 1'b0;
    wakeEn      = we;
    autoWakeEn  = ae;
    ctrlReg     = val;
    wakeFlagClr = 1'b1;
    @(negedge clk);
    wakeFlagClr = 1'b0;
    waitNeg(6);
    wrCnt = 0;
    goSleep();
    waitNeg(2);
    if (holdClr) wakeFlagClr = 1'b1;
    rxLine = 1'b0;
    if (we) begin
      waitNeg(2);
      chk(!wakeFlag && !coreClkEn, "R4", "no detection before third edge",
          {wakeFlag, coreClkEn}, 0);
      waitNeg(1);
      chk(wakeFlag && !coreStopReq && coreClkEn, "R4", "wake at third edge",
          {wakeFlag, coreStopReq, coreClkEn}, 3'b101);
      if (holdClr) begin
        waitNeg(1);
        chk(!wakeFlag, "R8", "clear after set cycle", wakeFlag, 0);
        wakeFlagClr = 1'b0;
      end
      rxLine = 1'b1;
      waitNeg(12);
      chk(coreStopReq == 1'b0, "R9", "held host request not re-armed", coreStopReq, 0);
      if (ae) begin
        chk(wrCnt == 1, "R5", "one write per wakeup", wrCnt, 1);
        chk(ctrlReg == expWord(val), "R5", "init bit cleared", ctrlReg, expWord(val));
      end else begin
        chk(wrCnt == 0, "R6", "no write without auto", wrCnt, 0);
        chk(ctrlReg == val, "R6", "word untouched", ctrlReg, val);
      end
      if (!holdClr) chk(wakeFlag, "R8", "flag sticky", wakeFlag, 1);
      @(negedge clk);
      wakeFlagClr = 1'b1;
      @(negedge clk);
      wakeFlagClr = 1'b0;
      chk(!wakeFlag, "R8", "flag cleared by write of one", wakeFlag, 0);
      hostStopReq = 1'b0;
      waitNeg(2);
      hostStopReq = 1'b1;
      waitNeg(2);
      chk(coreStopReq, "R9", "re-armed after low", coreStopReq, 1);
      hostStopReq = 1'b0;
      waitNeg(10);
    end else begin
      waitNeg(2);
      rxLine = 1'b1;
      waitNeg(6);
      wakeFlagClr = 1'b0;
      chk(!coreClkEn && coreStopReq, "R4", "activity ignored when disabled",
          {coreClkEn, coreStopReq}, 1);
      chk(!wakeFlag, "R4", "no flag when disabled", wakeFlag, 0);
      hostStopReq = 1'b0;
      waitNeg(10);
      chk(coreClkEn && !coreStopReq, "R7", "host ends sleep",
          {coreClkEn, coreStopReq}, 2'b10);
      chk(!wakeFlag && wrCnt == 0 && ctrlReg == val, "R7", "no flag or write",
          {wakeFlag, wrCnt[7:0]}, 0);
    end
  endtask

  initial begin
    ctrlReg = 16'h0009;
    void'($urandom(32'h0000_5EED));
    waitNeg(3);
    chk(!coreStopReq && coreClkEn && !wakeFlag && !rmwRdEn && !rmwWrEn, "R1",
        "reset outputs", {coreStopReq, coreClkEn, wakeFlag, rmwRdEn, rmwWrEn}, 5'b01000);
    rstN = 1'b1;
    waitNeg(2);
    chk(!coreStopReq && coreClkEn && !wakeFlag, "R1", "idle after reset",
        {coreStopReq, coreClkEn, wakeFlag}, 3'b010);

    // directed corners
    runCase(1'b1, 1'b1, 16'hFFFF, 1'b0);
    runCase(1'b1, 1'b1, 16'h0008, 1'b0);
    runCase(1'b1, 1'b0, 16'h00AA, 1'b0);
    runCase(1'b0, 1'b1, 16'h1234, 1'b0);
    runCase(1'b1, 1'b1, 16'h5A5F, 1'b1);

    // constrained random
    for (int k = 0; k < 30; k++) begin
      logic [REG_W-1:0] v;
      v = REG_W'($urandom);
      runCase(1'($urandom), 1'($urandom), v, ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule